// File: doc/BRIEF.md
# Boot-Strapped External Bus Gate

This block sits between a CPU's memory request and the external memory bus. For every access it decides whether the target is on-chip memory or an external device. It then either raises a one-hot select toward the internal memory that was hit, or drives active-low chip-enable, read and write strobes to the outside world. It also drives an output enable for the 8-bit external data bus.

A strap pin chooses how the low program region is treated:

- When the pin is high, the gate works in controller mode. The program region is served by internal memory.
- When the pin is low, the gate works in processor mode. The program region is handed to the external bus.

The pin is captured only while reset is held. Its value at the last clock edge before reset is released is kept until the next reset. Board-level pull-up on the strap makes controller mode the default.

Besides the program region, a parameterized number of further on-chip windows stay internal in both modes. Each window is given by an inclusive base and limit. When windows overlap, the internal target always wins, and the external locations beneath it cannot be reached. Any address that falls in no window goes to the external bus.

Top module: `xbus_gate`

## Requirements
- R1: The mode is taken from `mode_pin` at the last rising `clk` edge on which `rst_n` is low. Any change of `mode_pin` while `rst_n` is high has no effect until reset is asserted again.
- R2: A captured high selects controller mode, in which the program region is internal. A captured low selects processor mode, in which the program region is external.
- R3: In controller mode, an access whose address lies in [`PROG_BASE`, `PROG_LIMIT`] (default 0x0000 to 0x7FFF) sets `int_sel[0]`.
- R4: Whenever an access hits an internal target, `ext_ce_n`, `ext_rd_n` and `ext_wr_n` stay high and `ext_dq_oe` stays low.
- R5: `int_sel` has at most one bit set. Bit 0 is the program region and bit k+1 is window k. When windows overlap, the program region (in controller mode) beats every window, and a lower window index beats a higher one.
- R6: In processor mode, an access to the program region never sets `int_sel[0]`. If no window claims the address, the access drives `ext_ce_n` low together with `ext_rd_n` (read) or `ext_wr_n` (write).
- R7: In processor mode, accesses to the windows remain internal and produce no external strobe.
- R8: An access that hits no internal target goes to the external bus in either mode: `ext_ce_n` is low and exactly one of `ext_rd_n` or `ext_wr_n` is low.
- R9: `ext_dq_oe` is high only during an external write, and then `ext_dout` equals `cpu_wdata`; otherwise `ext_dout` is 0. During an external read, `cpu_rdata` equals `ext_din`; otherwise `cpu_rdata` is 0.
- R10: While `rst_n` is low, all three strobes are high, `ext_dq_oe` is low and `int_sel` is zero, whatever the request.
- R11: With neither `cpu_rd` nor `cpu_wr` set, `ext_ce_n` is high and `int_sel` is zero. With both set, the access is treated as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock used to sample the strap during reset |
| rst_n | input | 1 | Active-low reset; its release freezes the mode |
| mode_pin | input | 1 | Strap: 1 selects controller mode, 0 selects processor mode |
| cpu_addr | input | ADDR_W | Logical address of the current access |
| cpu_rd | input | 1 | Read request |
| cpu_wr | input | 1 | Write request (wins over read) |
| cpu_wdata | input | 8 | Write data from the CPU |
| cpu_rdata | output | 8 | Read data returned from the external bus |
| ext_din | input | 8 | Value sampled from the external data bus |
| ext_dout | output | 8 | Value driven onto the external data bus |
| ext_dq_oe | output | 1 | Output enable for the external data bus |
| ext_ce_n | output | 1 | External chip enable, active low |
| ext_rd_n | output | 1 | External read strobe, active low |
| ext_wr_n | output | 1 | External write strobe, active low |
| int_sel | output | N_AREAS+1 | One-hot select toward the internal target hit |

## Verification
The assertions assume three things about the inputs:

- Reset is held low for at least one rising clock edge, so the mode register holds a captured value before any property is enabled.
- Request and address inputs change away from the clock edge.
- The bench configuration's windows are ordered so that overlaps actually exercise the priority chain.

The stimulus meets these assumptions by driving every input only at falling edges or between edges, and by holding reset for several cycles. It also flips the strap to the opposite level right after each release, so every later vector doubles as a check that the pin is ignored. In a reduced 12-bit address space, every address with every request combination is swept in both modes.

// File: rtl/xbg_pkg.sv
package xbg_pkg;

  // Request kind after resolving simultaneous read and write.
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

  // Write takes precedence when both requests are raised together.
  function automatic acc_e resolve_acc(input logic rd, input logic wr);
    if (wr)      return ACC_WRITE;
    else if (rd) return ACC_READ;
    else         return ACC_NONE;
  endfunction

  // Data byte put on the external bus: only during an external write.
  function automatic logic [7:0] drive_byte(input logic oe, input logic [7:0] d);
    return oe ? d : 8'h00;
  endfunction

endpackage

// File: rtl/xbg_mode_latch.sv
module xbg_mode_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_pin,
  output logic mode_mcu
);

  logic strap_q;

  // The strap follows the pin on every edge inside reset and is frozen
  // once reset is released; the value seen last before release wins.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strap_q <= mode_pin;
    end
  end

  assign mode_mcu = strap_q;

endmodule

// File: rtl/xbg_region_dec.sv
module xbg_region_dec #(
  parameter int ADDR_W  = 16,
  parameter int N_AREAS = 2,
  parameter logic [ADDR_W-1:0]         PROG_BASE  = '0,
  parameter logic [ADDR_W-1:0]         PROG_LIMIT = 16'h7FFF,
  parameter logic [N_AREAS*ADDR_W-1:0] AREA_BASE  = {16'hF000, 16'h8000},
  parameter logic [N_AREAS*ADDR_W-1:0] AREA_LIMIT = {16'hF0FF, 16'h87FF}
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               mode_mcu,
  output logic [N_AREAS:0]   sel,
  output logic               hit
);

  localparam int NSEL = N_AREAS + 1;

  // Inclusive window compare.
  function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] lo,
                                     input logic [ADDR_W-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  logic [NSEL-1:0] raw;
  logic [NSEL:0]   taken;

  // Slot 0: program region, only internal in controller mode.
  assign raw[0] = mode_mcu && in_window(addr, PROG_BASE, PROG_LIMIT);

  genvar k;
  generate
    for (k = 0; k < N_AREAS; k++) begin : g_area
      assign raw[k+1] = in_window(addr,
                                  AREA_BASE[k*ADDR_W +: ADDR_W],
                                  AREA_LIMIT[k*ADDR_W +: ADDR_W]);
    end
  endgenerate

  // Fixed-priority chain: lower slot index wins.
  assign taken[0] = 1'b0;
  generate
    for (k = 0; k < NSEL; k++) begin : g_prio
      assign sel[k]     = raw[k] && !taken[k];
      assign taken[k+1] = taken[k] || raw[k];
    end
  endgenerate

  assign hit = taken[NSEL];

endmodule

// File: rtl/xbg_strobe.sv
module xbg_strobe
  import xbg_pkg::*;
(
  input  logic       run,
  input  acc_e       acc,
  input  logic       hit_int,
  input  logic [7:0] cpu_wdata,
  input  logic [7:0] ext_din,
  output logic       ext_ce_n,
  output logic       ext_rd_n,
  output logic       ext_wr_n,
  output logic       ext_dq_oe,
  output logic [7:0] ext_dout,
  output logic [7:0] cpu_rdata
);

  logic ext_go;
  logic ext_rd;
  logic ext_wr;

  assign ext_go = run && (acc != ACC_NONE) && !hit_int;
  assign ext_rd = ext_go && (acc == ACC_READ);
  assign ext_wr = ext_go && (acc == ACC_WRITE);

  assign ext_ce_n  = !ext_go;
  assign ext_rd_n  = !ext_rd;
  assign ext_wr_n  = !ext_wr;
  assign ext_dq_oe = ext_wr;
  assign ext_dout  = drive_byte(ext_wr, cpu_wdata);
  assign cpu_rdata = ext_rd ? ext_din : 8'h00;

endmodule

// File: rtl/xbus_gate.sv
module xbus_gate
  import xbg_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int N_AREAS = 2,
  parameter logic [ADDR_W-1:0]         PROG_BASE  = '0,
  parameter logic [ADDR_W-1:0]         PROG_LIMIT = 16'h7FFF,
  parameter logic [N_AREAS*ADDR_W-1:0] AREA_BASE  = {16'hF000, 16'h8000},
  parameter logic [N_AREAS*ADDR_W-1:0] AREA_LIMIT = {16'hF0FF, 16'h87FF}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_pin,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  input  logic [7:0]        ext_din,
  output logic [7:0]        ext_dout,
  output logic              ext_dq_oe,
  output logic              ext_ce_n,
  output logic              ext_rd_n,
  output logic              ext_wr_n,
  output logic [N_AREAS:0]  int_sel
);

  localparam int NSEL = N_AREAS + 1;

  // Named internal events, brought out for the checker.
  logic            mode_mcu;
  logic            hit_int;
  logic            access;
  logic [NSEL-1:0] dec_sel;
  acc_e            acc;

  assign acc    = resolve_acc(cpu_rd, cpu_wr);
  assign access = (acc != ACC_NONE);

  xbg_mode_latch u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_pin (mode_pin),
    .mode_mcu (mode_mcu)
  );

  xbg_region_dec #(
    .ADDR_W     (ADDR_W),
    .N_AREAS    (N_AREAS),
    .PROG_BASE  (PROG_BASE),
    .PROG_LIMIT (PROG_LIMIT),
    .AREA_BASE  (AREA_BASE),
    .AREA_LIMIT (AREA_LIMIT)
  ) u_dec (
    .addr     (cpu_addr),
    .mode_mcu (mode_mcu),
    .sel      (dec_sel),
    .hit      (hit_int)
  );

  xbg_strobe u_strb (
    .run       (rst_n),
    .acc       (acc),
    .hit_int   (hit_int),
    .cpu_wdata (cpu_wdata),
    .ext_din   (ext_din),
    .ext_ce_n  (ext_ce_n),
    .ext_rd_n  (ext_rd_n),
    .ext_wr_n  (ext_wr_n),
    .ext_dq_oe (ext_dq_oe),
    .ext_dout  (ext_dout),
    .cpu_rdata (cpu_rdata)
  );

  assign int_sel = (rst_n && access) ? dec_sel : '0;

endmodule

// File: rtl/xbg_checker.sv
module xbg_checker #(
  parameter int NSEL = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mode_mcu,
  input logic            hit_int,
  input logic            access,
  input logic            cpu_wr,
  input logic [NSEL-1:0] int_sel,
  input logic            ext_ce_n,
  input logic            ext_rd_n,
  input logic            ext_wr_n,
  input logic            ext_dq_oe
);

  // R1: frozen mode outside reset
  assert_mode_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_mcu));

  // R4: internal hit keeps the external bus silent
  assert_int_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_int |-> (ext_ce_n && ext_rd_n && ext_wr_n && !ext_dq_oe));

  // R5: at most one internal target
  assert_sel_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(int_sel));

  // R6: program slot never chosen in processor mode
  assert_prog_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_mcu |-> !int_sel[0]);

  // R8: a miss with a request goes out with exactly one strobe
  assert_miss_ext_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (access && !hit_int) |-> (!ext_ce_n && $countones({ext_rd_n, ext_wr_n}) == 1));

  // R9: bus driven only for a write strobe
  assert_oe_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ext_dq_oe |-> (!ext_wr_n && cpu_wr));

  // R10: silent during reset
  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rst_n |-> (ext_ce_n && ext_rd_n && ext_wr_n && !ext_dq_oe && int_sel == '0));

  // R11: idle cycle selects nothing
  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !access |-> (ext_ce_n && int_sel == '0));

endmodule

bind xbus_gate xbg_checker #(.NSEL(N_AREAS + 1)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_mcu  (mode_mcu),
  .hit_int   (hit_int),
  .access    (access),
  .cpu_wr    (cpu_wr),
  .int_sel   (int_sel),
  .ext_ce_n  (ext_ce_n),
  .ext_rd_n  (ext_rd_n),
  .ext_wr_n  (ext_wr_n),
  .ext_dq_oe (ext_dq_oe)
);

// File: tb/sim_xbus_gate.sv
`timescale 1ns/1ps
module sim_xbus_gate;

  localparam int AW = 12;
  localparam int NA = 2;
  // Program 0x000..0x7FF; window0 0x700..0x9FF (overlaps program);
  // window1 0x900..0x93F (inside window0, so window0 wins).
  localparam logic [AW-1:0]    P_LIM = 12'h7FF;
  localparam logic [NA*AW-1:0] A_B   = {12'h900, 12'h700};
  localparam logic [NA*AW-1:0] A_L   = {12'h93F, 12'h9FF};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_pin = 1'b1;
  logic [AW-1:0] cpu_addr = '0;
  logic          cpu_rd = 1'b0;
  logic          cpu_wr = 1'b0;
  logic [7:0]    cpu_wdata = '0;
  logic [7:0]    ext_din = '0;
  logic [7:0]    cpu_rdata;
  logic [7:0]    ext_dout;
  logic          ext_dq_oe;
  logic          ext_ce_n;
  logic          ext_rd_n;
  logic          ext_wr_n;
  logic [NA:0]   int_sel;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  xbus_gate #(
    .ADDR_W(AW), .N_AREAS(NA), .PROG_BASE('0), .PROG_LIMIT(P_LIM),
    .AREA_BASE(A_B), .AREA_LIMIT(A_L)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .mode_pin(mode_pin), .cpu_addr(cpu_addr),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .ext_din(ext_din), .ext_dout(ext_dout),
    .ext_dq_oe(ext_dq_oe), .ext_ce_n(ext_ce_n), .ext_rd_n(ext_rd_n),
    .ext_wr_n(ext_wr_n), .int_sel(int_sel)
  );

  // Expected select computed from the window list, independent of the RTL.
  function automatic logic [NA:0] model_sel(input int a, input bit mcu, input bit req);
    if (!req) return '0;
    if (mcu && a <= 'h7FF) return 3'b001;
    if (a >= 'h700 && a <= 'h9FF) return 3'b010;
    if (a >= 'h900 && a <= 'h93F) return 3'b100;
    return '0;
  endfunction

  task automatic check(input string tag, input logic [27:0] act, input logic [27:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s addr=%h rd=%b wr=%b act=%h exp=%h", tag, cpu_addr, cpu_rd, cpu_wr, act, exp);
    end
  endtask

  function automatic logic [27:0] observe();
    return {5'b0, ext_ce_n, ext_rd_n, ext_wr_n, ext_dq_oe, ext_dout, cpu_rdata, int_sel};
  endfunction

  task automatic apply(input int a, input int op, input bit mcu, input bit in_rst);
    logic [NA:0] s;
    bit req, wr, rd, ext;
    logic [27:0] e;
    string tag;
    cpu_addr = a[AW-1:0];
    cpu_rd = op[0];
    cpu_wr = op[1];
    cpu_wdata = a[7:0] ^ 8'h5A;
    ext_din = ~a[7:0];
    #0.2;
    req = (op != 0) && !in_rst;
    wr = req && op[1];
    rd = req && op[0] && !op[1];
    s = model_sel(a, mcu, req);
    ext = req && (s == '0);
    e = {5'b0, !ext, !(ext && rd), !(ext && wr), ext && wr,
         (ext && wr) ? cpu_wdata : 8'h00, (ext && rd) ? ext_din : 8'h00, s};
    if (in_rst) tag = "R10";
    else if (op == 0 || op == 3) tag = "R11";
    else if (s == 3'b001) tag = "R3/R2";
    else if (a >= 'h700 && a <= 'h93F && (mcu || a >= 'h900)) tag = "R5";
    else if (s != '0) tag = mcu ? "R4" : "R7/R4";
    else if (a <= 'h7FF) tag = "R6/R9";
    else tag = "R8/R9";
    check(tag, observe(), e);
  endtask

  // Strap toggles inside reset; the last value before release must stick.
  task automatic do_reset(input bit final_pin);
    @(negedge clk);
    rst_n = 1'b0;
    mode_pin = ~final_pin;
    repeat (3) @(negedge clk);
    mode_pin = final_pin;
    repeat (2) @(negedge clk);
    // R10: requests during reset produce nothing
    apply('h000, 1, final_pin, 1'b1);
    apply('hC00, 2, final_pin, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    mode_pin = ~final_pin;  // R1: must be ignored from here on
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int m = 1; m >= 0; m--) begin
      do_reset(m[0]);
      // R1/R2: program base read shows the captured mode despite pin flip
      apply('h000, 1, m[0], 1'b0);
      for (int a = 0; a < (1 << AW); a++) begin
        for (int op = 0; op < 4; op++) begin
          apply(a, op, m[0], 1'b0);
        end
      end
    end
    // R1: a new reset re-captures; controller mode again
    do_reset(1'b1);
    apply('h7FF, 2, 1'b1, 1'b0);
    apply('h800, 2, 1'b1, 1'b0);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule